// File: doc/BRIEF.md
# ADC Standby Power-Cycling Sequencer

This controller sits on the host side of a multichannel sampling converter and cuts its average power by keeping it in low-current standby except while a conversion sequence is running. A one-cycle sample request releases the converter from standby and starts a wake-up wait. It then issues an active-low convert-start pulse, follows the converter's busy flag through the sequence, and returns the converter to standby as soon as busy falls.

The wake-up wait depends on how long the converter has been idle. The first wake after reset uses a long power-up count, which covers internal reference settling. After that, a short count applies when the converter slept for less than a programmable idle limit, and a longer count applies when it slept past that limit. All intervals are given in clock cycles. The asynchronous busy input passes through a synchronizer of parameterised depth. A sample request that arrives while a sequence is still in progress sets a sticky overrun flag and is otherwise dropped.

Top module: `adc_standby_sequencer`

## Requirements
- R1: During and after reset, with no request: `standbyN` is 0 (converter in standby), `convStartN` is 1, and `overrunFlag` is 0.
- R2: The first request after reset sets `standbyN` to 1 one cycle after the request cycle. `convStartN` first goes low exactly `WAKE_POWERUP_CYC`+1 cycles after `standbyN` rises. This holds again after every later reset.
- R3: For a request accepted after a standby period shorter than `IDLE_LONG_CYC` cycles, `convStartN` first goes low exactly `WAKE_SHORT_CYC`+1 cycles after `standbyN` rises.
- R4: For a request accepted after a standby period longer than `IDLE_LONG_CYC` cycles, `convStartN` first goes low exactly `WAKE_LONG_CYC`+1 cycles after `standbyN` rises.
- R5: `convStartN` is low for exactly `CONV_PULSE_CYC` consecutive cycles, once per sequence. It is low only while `standbyN` is 1, and only after the wake-up wait has completed.
- R6: `standbyN` stays 1 while `busyIn` is 1. It goes to 0 exactly `SYNC_STAGES`+1 cycles after `busyIn` falls.
- R7: A request that arrives while `standbyN` is 1 sets `overrunFlag` to 1. It does not change the timing of the running sequence and does not start another one. `overrunFlag` stays 1 until reset.
- R8: A request that arrives while the converter is in standby never sets `overrunFlag`.
- R9: Without a request, `standbyN` stays 0 and no convert-start pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | One-cycle sample request |
| busyIn | input | 1 | Converter busy flag, asynchronous, high while converting |
| standbyN | output | 1 | Active-low standby control: 0 holds the converter in standby |
| convStartN | output | 1 | Active-low convert-start pulse |
| overrunFlag | output | 1 | Sticky flag: a request arrived during a sequence |

## Verification
Most wrong internal states in this block show up as a cycle-count error at the ports. If the wake counter is loaded with the wrong length, or the idle counter picks the wrong class, the convert-start edge moves away from its expected offset from the standby release. This is visible within one wake interval. A state machine that loses track of busy either holds the converter awake after busy falls, which shows within `SYNC_STAGES`+1 cycles, or starts a second pulse. If the power-up marker is not cleared, every later short wake comes out at the power-up length.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    ST_SLEEP,
    ST_WAKE,
    ST_READY,
    ST_PULSE,
    ST_WAIT_BUSY,
    ST_CONVERT
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadWake;
    logic runWake;
    logic loadPulse;
    logic runPulse;
    logic clearIdle;
    logic runIdle;
  } seqStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic wakeDone;
    logic pulseDone;
    logic busySync;
    logic idleLong;
    logic firstWake;
  } seqStatus_t;

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int WAKE_SHORT_CYC   = 400,
  parameter int WAKE_LONG_CYC    = 2000,
  parameter int WAKE_POWERUP_CYC = 1200000,
  parameter int IDLE_LONG_CYC    = 200000,
  parameter int CONV_PULSE_CYC   = 4,
  parameter int SYNC_STAGES      = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busyIn,
  input  seqStrobe_t strb,
  output seqStatus_t stat
);

  localparam int WAKE_MAX_A = (WAKE_SHORT_CYC > WAKE_LONG_CYC) ? WAKE_SHORT_CYC : WAKE_LONG_CYC;
  localparam int WAKE_MAX   = (WAKE_MAX_A > WAKE_POWERUP_CYC) ? WAKE_MAX_A : WAKE_POWERUP_CYC;
  localparam int WAKE_W     = $clog2(WAKE_MAX + 1);
  localparam int IDLE_W     = $clog2(IDLE_LONG_CYC + 1);
  localparam int PULSE_W    = $clog2(CONV_PULSE_CYC + 1);

  // Busy synchronizer, depth chosen by parameter (0 = pass-through)
  logic syncChain [SYNC_STAGES+1];
  assign syncChain[0] = busyIn;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncChain[i+1] <= 1'b0;
        else       syncChain[i+1] <= syncChain[i];
      end
    end
  endgenerate

  // Idle-time measurement, saturating at the long-idle limit
  logic [IDLE_W-1:0] idleCnt;
  logic              idleSat;
  assign idleSat = (idleCnt == IDLE_W'(IDLE_LONG_CYC));

  always_ff @(posedge clk) begin
    if (!rstN)                     idleCnt <= '0;
    else if (strb.clearIdle)       idleCnt <= '0;
    else if (strb.runIdle && !idleSat) idleCnt <= idleCnt + 1'b1;
  end

  // Power-up marker: set by reset, cleared by the first wake
  logic firstWake;
  always_ff @(posedge clk) begin
    if (!rstN)              firstWake <= 1'b1;
    else if (strb.loadWake) firstWake <= 1'b0;
  end

  // Wake-up length selection and down-counter
  logic [WAKE_W-1:0] wakeLoad;
  logic [WAKE_W-1:0] wakeCnt;

  always_comb begin
    if (firstWake)    wakeLoad = WAKE_W'(WAKE_POWERUP_CYC - 1);
    else if (idleSat) wakeLoad = WAKE_W'(WAKE_LONG_CYC - 1);
    else              wakeLoad = WAKE_W'(WAKE_SHORT_CYC - 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              wakeCnt <= '0;
    else if (strb.loadWake)                 wakeCnt <= wakeLoad;
    else if (strb.runWake && wakeCnt != '0) wakeCnt <= wakeCnt - 1'b1;
  end

  // Convert-start pulse width counter
  logic [PULSE_W-1:0] pulseCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                                pulseCnt <= '0;
    else if (strb.loadPulse)                  pulseCnt <= PULSE_W'(CONV_PULSE_CYC - 1);
    else if (strb.runPulse && pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
  end

  assign stat.wakeDone  = (wakeCnt == '0);
  assign stat.pulseDone = (pulseCnt == '0);
  assign stat.busySync  = syncChain[SYNC_STAGES];
  assign stat.idleLong  = idleSat;
  assign stat.firstWake = firstWake;

  // R4: idle counter never passes its limit
  assert_idle_saturate_R4: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt <= IDLE_W'(IDLE_LONG_CYC));

  // R5: at most one load strobe per cycle
  assert_single_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadWake, strb.loadPulse, strb.clearIdle}));

  // R2: power-up length is used only once after reset
  assert_first_wake_once_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWake |=> !firstWake);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  seqStatus_t stat,
  output seqStrobe_t strb,
  output logic       standbyN,
  output logic       convStartN,
  output logic       overrunFlag
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_SLEEP: begin
        strb.runIdle = 1'b1;
        if (sampleTick) begin
          strb.loadWake = 1'b1;
          stateNext     = ST_WAKE;
        end
      end
      ST_WAKE: begin
        if (stat.wakeDone) stateNext = ST_READY;
        else               strb.runWake = 1'b1;
      end
      ST_READY: begin
        strb.loadPulse = 1'b1;
        stateNext      = ST_PULSE;
      end
      ST_PULSE: begin
        if (stat.pulseDone) stateNext = ST_WAIT_BUSY;
        else                strb.runPulse = 1'b1;
      end
      ST_WAIT_BUSY: begin
        if (stat.busySync) stateNext = ST_CONVERT;
      end
      ST_CONVERT: begin
        if (!stat.busySync) begin
          strb.clearIdle = 1'b1;
          stateNext      = ST_SLEEP;
        end
      end
      default: stateNext = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_SLEEP;
    else       state <= stateNext;
  end

  // Sticky overrun: request seen outside standby
  always_ff @(posedge clk) begin
    if (!rstN)                                overrunFlag <= 1'b0;
    else if (sampleTick && state != ST_SLEEP) overrunFlag <= 1'b1;
  end

  assign standbyN   = (state != ST_SLEEP);
  assign convStartN = (state != ST_PULSE);

  // R5: a pulse begins only from the ready state
  assert_pulse_from_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PULSE && $past(state) != ST_PULSE) |-> $past(state) == ST_READY);

  // R7: overrun is sticky
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    overrunFlag |=> overrunFlag);

  // R8: overrun rises only for a request outside standby
  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> ($past(sampleTick) && $past(state) != ST_SLEEP));

endmodule

// File: rtl/adc_standby_sequencer.sv
module adc_standby_sequencer
  import seq_pkg::*;
#(
  parameter int WAKE_SHORT_CYC   = 400,
  parameter int WAKE_LONG_CYC    = 2000,
  parameter int WAKE_POWERUP_CYC = 1200000,
  parameter int IDLE_LONG_CYC    = 200000,
  parameter int CONV_PULSE_CYC   = 4,
  parameter int SYNC_STAGES      = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sampleTick,
  input  logic busyIn,
  output logic standbyN,
  output logic convStartN,
  output logic overrunFlag
);

  seqStrobe_t strb;
  seqStatus_t stat;

  seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleTick  (sampleTick),
    .stat        (stat),
    .strb        (strb),
    .standbyN    (standbyN),
    .convStartN  (convStartN),
    .overrunFlag (overrunFlag)
  );

  seq_datapath #(
    .WAKE_SHORT_CYC   (WAKE_SHORT_CYC),
    .WAKE_LONG_CYC    (WAKE_LONG_CYC),
    .WAKE_POWERUP_CYC (WAKE_POWERUP_CYC),
    .IDLE_LONG_CYC    (IDLE_LONG_CYC),
    .CONV_PULSE_CYC   (CONV_PULSE_CYC),
    .SYNC_STAGES      (SYNC_STAGES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .busyIn (busyIn),
    .strb   (strb),
    .stat   (stat)
  );

  // R5: convert start only while awake
  assert_convst_awake_R5: assert property (@(posedge clk) disable iff (!rstN)
    !convStartN |-> standbyN);

  // R6: standby entered only once busy is low
  assert_sleep_after_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(standbyN) |-> !busyIn);

endmodule

// File: tb/tb_adc_standby_sequencer.sv
module tb_adc_standby_sequencer;

  localparam int P_SHORT = 5;
  localparam int P_LONG  = 12;
  localparam int P_PWR   = 30;
  localparam int P_IDLE  = 50;
  localparam int P_PULSE = 3;
  localparam int P_SYNC  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b0;
  logic busyIn = 1'b0;
  logic standbyN, convStartN, overrunFlag;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  adc_standby_sequencer #(
    .WAKE_SHORT_CYC   (P_SHORT),
    .WAKE_LONG_CYC    (P_LONG),
    .WAKE_POWERUP_CYC (P_PWR),
    .IDLE_LONG_CYC    (P_IDLE),
    .CONV_PULSE_CYC   (P_PULSE),
    .SYNC_STAGES      (P_SYNC)
  ) dut (
    .clk         (clk),
    .rstN        (rstN),
    .sampleTick  (sampleTick),
    .busyIn      (busyIn),
    .standbyN    (standbyN),
    .convStartN  (convStartN),
    .overrunFlag (overrunFlag)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    sampleTick = 1'b0;
    busyIn = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 standbyN in reset", standbyN, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 standbyN after reset", standbyN, 0);
    check("R1 convStartN after reset", convStartN, 1);
    check("R1 overrunFlag after reset", overrunFlag, 0);
  endtask

  // One full sequence with a behavioural converter model.
  // extraAt: wake-count value at which a stray request is driven (-1 none)
  task automatic runSequence(input int expWake, input string tag,
                             input int extraAt, input bit busyTick);
    int cnt;
    int width;
    bit awakeOk;
    @(negedge clk);
    sampleTick = 1'b1;
    @(negedge clk);
    sampleTick = 1'b0;
    check({tag, " standbyN one cycle after request"}, standbyN, 1);
    cnt = 0;
    while (cnt < 5000) begin
      @(negedge clk);
      cnt++;
      sampleTick = (cnt == extraAt);
      if (!convStartN) break;
    end
    sampleTick = 1'b0;
    check({tag, " wake cycles to convStartN"}, cnt, expWake + 1);
    width = 1;
    awakeOk = standbyN;
    while (width < 100) begin
      @(negedge clk);
      if (convStartN) break;
      width++;
      awakeOk &= standbyN;
    end
    check("R5 convStartN pulse width", width, P_PULSE);
    check("R5 standbyN high during pulse", awakeOk, 1);
    repeat (2) @(negedge clk);
    busyIn = 1'b1;
    awakeOk = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      sampleTick = busyTick && (i == 5);
      awakeOk &= standbyN & convStartN;
    end
    sampleTick = 1'b0;
    check("R6 awake with no second pulse while busy", awakeOk, 1);
    busyIn = 1'b0;
    cnt = 0;
    while (cnt < 100) begin
      @(negedge clk);
      cnt++;
      if (!standbyN) break;
    end
    check("R6 cycles from busy fall to standby", cnt, P_SYNC + 1);
  endtask

  task automatic testNoRequest();
    bit quiet = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      quiet &= !standbyN & convStartN;
    end
    check("R9 no activity without request", quiet, 1);
  endtask

  task automatic testPowerUp();
    runSequence(P_PWR, "R2", -1, 1'b0);
    check("R8 no overrun after normal sequence", overrunFlag, 0);
  endtask

  task automatic testShortIdle();
    repeat (3) @(negedge clk);
    runSequence(P_SHORT, "R3", -1, 1'b0);
    check("R8 no overrun after request in standby", overrunFlag, 0);
  endtask

  task automatic testLongIdle();
    repeat (P_IDLE + 30) @(negedge clk);
    runSequence(P_LONG, "R4", -1, 1'b0);
  endtask

  task automatic testOverrun();
    runSequence(P_SHORT, "R7", 2, 1'b1);
    check("R7 overrun set", overrunFlag, 1);
    testNoRequest();
    check("R7 overrun still set", overrunFlag, 1);
    runSequence(P_SHORT, "R3", -1, 1'b0);
    check("R7 overrun sticky across sequence", overrunFlag, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    testNoRequest();
    testPowerUp();
    testShortIdle();
    testLongIdle();
    testShortIdle();
    testOverrun();
    doReset();
    check("R7 overrun cleared by reset", overrunFlag, 0);
    testPowerUp();
    testShortIdle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule